// File: doc/BRIEF.md
# Pause Frame Transmit Controller

This block turns a host request for link flow control into action on the link. The host programs a 16-bit pause time and sets a request bit in one control register. If the link runs full duplex, the block emits a complete MAC control frame as a byte stream toward the MAC transmit path. That frame is a PAUSE command carrying the programmed time, padded to minimum length, and closed by a four-byte frame check sequence. If the link runs half duplex, the same request raises a back-pressure level toward the link logic, and nothing is transmitted.

A single busy flag shows the host what is in progress. In full duplex it means a frame is still being handed over. In half duplex it means back pressure is being held. While busy is set, the register ignores writes. The one exception is the write that ends back pressure. No request is acted on while the transmitter enable input is low.

The controller has four states:
- `ST_IDLE`: nothing in progress.
- `ST_FRAME`: sending the 60 header and pad bytes.
- `ST_FCS`: sending the four check bytes.
- `ST_HOLD`: back pressure asserted.

Its transitions are:
- IDLE→FRAME: an accepted request while full duplex.
- IDLE→HOLD: an accepted request while half duplex.
- FRAME→FCS: byte 59 accepted.
- FCS→IDLE: byte 63 accepted.
- HOLD→IDLE: a release write, or the transmitter enable going low.

Top module: `pause_tx_ctrl`

## Requirements
- R1: After reset, busy, back_pressure and tx_valid are 0 and cfg_rd_data reads 0.
- R2: The readback layout is cfg_rd_data[31:16] = stored pause time, bit 1 = back_pressure, bit 0 = busy, and all other bits 0. A write while idle stores cfg_wr_data[31:16] as the pause time. Bit 0 of a write is the request.
- R3: A full-duplex request produces 64 bytes in this order:
  - bytes 0–5: 01 80 C2 00 00 01
  - bytes 6–11: station_addr, most significant byte first
  - bytes 12–13: 88 08
  - bytes 14–15: 00 01
  - bytes 16–17: the pause time, high byte first
  - bytes 18–59: zero
- R4: Bytes 60–63 carry the frame check sequence. It is the complement of the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones) over bytes 0–59, sent least significant byte first. tx_last is high on byte 63 only.
- R5: While tx_valid is high and tx_ready is low, tx_data and tx_last hold steady. A byte advances only when it is accepted.
- R6: In full duplex, busy rises in the cycle after the accepting write. It falls in the cycle after the byte with tx_last is accepted.
- R7: In half duplex, a request raises back_pressure and busy in the cycle after the write, and tx_valid stays 0.
- R8: In half duplex, a write with bit 0 clear while back pressure is held drops back_pressure and busy in the next cycle.
- R9: With tx_enable low, a request starts no frame and no back pressure, though the pause time is still stored. tx_enable going low during back pressure releases it in the next cycle.
- R10: A write while busy does not change the stored pause time. In half duplex, a write with bit 0 set while busy leaves back pressure held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 32 | Write data: [31:16] pause time, [0] request |
| cfg_rd_data | output | 32 | Readback: [31:16] pause time, [1] back pressure, [0] busy |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex (sampled at request) |
| tx_enable | input | 1 | Transmitter enabled |
| station_addr | input | 48 | Source address placed in the frame |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Sink accepts the byte this cycle |
| tx_last | output | 1 | Final byte of the frame |
| back_pressure | output | 1 | Back pressure toward the link |
| busy | output | 1 | Frame in flight or back pressure held |

## Verification
The assertions assume that the sink applies tx_ready only as an acceptance signal. They also assume that the host does not need the FCS to restart after a mid-frame reset, since reset is synchronous and returns everything to idle.

The stimulus changes cfg_wr_en, tx_enable and full_duplex only between clock edges. It keeps full_duplex steady around each accepting write, and it drops tx_enable only while idle or during back pressure, never in the middle of a frame. Together these keep the stream-stability and busy-window properties meaningful.

// File: rtl/pause_pkg.sv
package pause_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_FCS,
        ST_HOLD
    } pstate_e;

    localparam logic [47:0] PAUSE_DST_ADDR = 48'h0180_C200_0001;
    localparam logic [15:0] MAC_CTRL_TYPE  = 16'h8808;
    localparam logic [15:0] PAUSE_OPCODE   = 16'h0001;
    localparam logic [31:0] CRC_POLY_REFL  = 32'hEDB8_8320;

    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) begin
            if (r[0]) r = (r >> 1) ^ CRC_POLY_REFL;
            else      r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/pause_cfg_reg.sv
module pause_cfg_reg #(
    parameter int PT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PT_W-1:0] pt_in,
    output logic [PT_W-1:0] pt_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_q <= '0;
        end else if (load) begin
            pt_q <= pt_in;
        end
    end

endmodule

// File: rtl/pause_byte_gen.sv
module pause_byte_gen
    import pause_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int PT_W  = 16
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [47:0]      src_addr,
    input  logic [PT_W-1:0]  ptime,
    output logic [7:0]       byte_o
);

    localparam int DST_END  = 6;
    localparam int SRC_END  = 12;
    localparam int TYPE_POS = 12;
    localparam int OPC_POS  = 14;
    localparam int PT_POS   = 16;

    int pos;
    assign pos = int'(idx);

    always_comb begin
        byte_o = '0;
        if (pos < DST_END) begin
            byte_o = PAUSE_DST_ADDR[8*(DST_END-1-pos) +: 8];
        end else if (pos < SRC_END) begin
            byte_o = src_addr[8*(SRC_END-1-pos) +: 8];
        end else if (pos == TYPE_POS) begin
            byte_o = MAC_CTRL_TYPE[15:8];
        end else if (pos == TYPE_POS + 1) begin
            byte_o = MAC_CTRL_TYPE[7:0];
        end else if (pos == OPC_POS) begin
            byte_o = PAUSE_OPCODE[15:8];
        end else if (pos == OPC_POS + 1) begin
            byte_o = PAUSE_OPCODE[7:0];
        end else if (pos == PT_POS) begin
            byte_o = ptime[15:8];
        end else if (pos == PT_POS + 1) begin
            byte_o = ptime[7:0];
        end
    end

endmodule

// File: rtl/pause_fcs.sv
module pause_fcs
    import pause_pkg::*;
#(
    parameter int FCS_LEN = 4,
    parameter int SEL_W   = (FCS_LEN > 1) ? $clog2(FCS_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             update,
    input  logic [7:0]       din,
    input  logic [SEL_W-1:0] sel,
    output logic [7:0]       fcs_byte
);

    logic [31:0] crc_q;
    logic [31:0] fcs_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (clear) begin
            crc_q <= '1;
        end else if (update) begin
            crc_q <= crc32_byte(crc_q, din);
        end
    end

    assign fcs_word = ~crc_q;
    assign fcs_byte = fcs_word[8*sel +: 8];

endmodule

// File: rtl/pause_tx_ctrl.sv
module pause_tx_ctrl
    import pause_pkg::*;
#(
    parameter int MIN_FRAME = 60,
    parameter int FCS_LEN   = 4,
    parameter int PT_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [31:0] cfg_wr_data,
    output logic [31:0] cfg_rd_data,
    input  logic        full_duplex,
    input  logic        tx_enable,
    input  logic [47:0] station_addr,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic        tx_last,
    output logic        back_pressure,
    output logic        busy
);

    localparam int TOTAL = MIN_FRAME + FCS_LEN;
    localparam int IDX_W = $clog2(TOTAL);
    localparam int SEL_W = (FCS_LEN > 1) ? $clog2(FCS_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(MIN_FRAME - 1);
    localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(TOTAL - 1);
    localparam logic [IDX_W-1:0] FCS_BASE  = IDX_W'(MIN_FRAME);

    pstate_e          state_q;
    pstate_e          state_d;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_rel;
    logic [PT_W-1:0]  pt_q;
    logic             wr_idle;
    logic             start;
    logic             release_bp;
    logic             take;
    logic [7:0]       hdr_byte;
    logic [7:0]       fcs_byte;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^cfg_wr_data[15:1];

    // write acceptance and request decode
    assign wr_idle    = cfg_wr_en && (state_q == ST_IDLE);
    assign start      = wr_idle && cfg_wr_data[0] && tx_enable;
    assign release_bp = (state_q == ST_HOLD) &&
                        ((cfg_wr_en && !cfg_wr_data[0]) || !tx_enable);
    assign take       = tx_valid && tx_ready;

    pause_cfg_reg #(.PT_W(PT_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_idle),
        .pt_in (cfg_wr_data[31:16]),
        .pt_q  (pt_q)
    );

    pause_byte_gen #(.IDX_W(IDX_W), .PT_W(PT_W)) u_gen (
        .idx      (idx_q),
        .src_addr (station_addr),
        .ptime    (pt_q),
        .byte_o   (hdr_byte)
    );

    assign idx_rel = idx_q - FCS_BASE;

    pause_fcs #(.FCS_LEN(FCS_LEN), .SEL_W(SEL_W)) u_fcs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .update   (take && (state_q == ST_FRAME)),
        .din      (hdr_byte),
        .sel      (idx_rel[SEL_W-1:0]),
        .fcs_byte (fcs_byte)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = full_duplex ? ST_FRAME : ST_HOLD;
            end
            ST_FRAME: begin
                if (take && idx_q == LAST_DATA) state_d = ST_FCS;
            end
            ST_FCS: begin
                if (take && idx_q == LAST_BYTE) state_d = ST_IDLE;
            end
            ST_HOLD: begin
                if (release_bp) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and byte index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                idx_q <= '0;
            end else if (take) begin
                idx_q <= (idx_q == LAST_BYTE) ? '0 : idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tx_valid      = 1'b0;
        tx_last       = 1'b0;
        tx_data       = '0;
        back_pressure = 1'b0;
        busy          = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_FRAME: begin
                tx_valid = 1'b1;
                tx_data  = hdr_byte;
            end
            ST_FCS: begin
                tx_valid = 1'b1;
                tx_data  = fcs_byte;
                tx_last  = (idx_q == LAST_BYTE);
            end
            ST_HOLD: back_pressure = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign cfg_rd_data = {pt_q, 14'h0, back_pressure, busy};

endmodule

// File: rtl/pause_tx_ctrl_chk.sv
module pause_tx_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [31:0] cfg_rd_data,
    input logic        tx_enable,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        tx_last,
    input logic [7:0]  tx_data,
    input logic        busy,
    input logic        back_pressure
);

    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    p_last_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    p_busy_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !busy);

    p_frame_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    p_no_frame_bp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        back_pressure |-> (!tx_valid && busy));

    p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && !busy) |=> !busy);

    p_disabled_nobp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> !back_pressure);

    p_busy_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr_en) |=> $stable(cfg_rd_data[31:16]));

endmodule

bind pause_tx_ctrl pause_tx_ctrl_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_rd_data   (cfg_rd_data),
    .tx_enable     (tx_enable),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_last       (tx_last),
    .tx_data       (tx_data),
    .busy          (busy),
    .back_pressure (back_pressure)
);

// File: tb/pause_tx_ctrl_tb_top.sv
module pause_tx_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 50000;
    localparam int NVEC       = 4;

    // {pause time 16, station address 48, ready mask 8}
    localparam logic [71:0] VEC [NVEC] = '{
        {16'h0001, 48'h0011_2233_4455, 8'hFF},
        {16'hFFFF, 48'hA0B1_C2D3_E4F5, 8'b1010_1101},
        {16'h1234, 48'h0200_0000_0001, 8'b0001_0011},
        {16'h0000, 48'hFFFF_FFFF_FFFE, 8'b0111_1110}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        full_duplex = 1'b1;
    logic        tx_enable = 1'b1;
    logic [47:0] station_addr = '0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        tx_last;
    logic        back_pressure;
    logic        busy;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    logic [7:0] exp_b [64];
    logic [7:0] got_b [80];
    int nbytes;
    int last_pos;
    int stable_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    pause_tx_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_wr_data   (cfg_wr_data),
        .cfg_rd_data   (cfg_rd_data),
        .full_duplex   (full_duplex),
        .tx_enable     (tx_enable),
        .station_addr  (station_addr),
        .tx_data       (tx_data),
        .tx_valid      (tx_valid),
        .tx_ready      (tx_ready),
        .tx_last       (tx_last),
        .back_pressure (back_pressure),
        .busy          (busy)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < %0d)", cyc, WDOG_LIMIT);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic build_expected(input logic [15:0] pt, input logic [47:0] mac);
        logic [31:0] c;
        logic [47:0] dst;
        dst = 48'h0180_C200_0001;
        for (int i = 0; i < 60; i++) exp_b[i] = 8'h00;
        for (int i = 0; i < 6; i++) begin
            exp_b[i]     = dst[47-8*i -: 8];
            exp_b[6 + i] = mac[47-8*i -: 8];
        end
        exp_b[12] = 8'h88; exp_b[13] = 8'h08;
        exp_b[14] = 8'h00; exp_b[15] = 8'h01;
        exp_b[16] = pt[15:8]; exp_b[17] = pt[7:0];
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 60; i++) begin
            c = c ^ {24'h0, exp_b[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        c = ~c;
        for (int i = 0; i < 4; i++) exp_b[60 + i] = c[8*i +: 8];
    endtask

    // called at a negedge; returns at a negedge
    task automatic do_write(input logic [31:0] d);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        cfg_wr_data = '0;
    endtask

    task automatic collect(input logic [7:0] mask);
        int c;
        logic held;
        logic [7:0] hd;
        logic hl;
        c = 0; nbytes = 0; last_pos = -1; stable_err = 0; held = 1'b0; hd = '0; hl = 1'b0;
        while (last_pos < 0 && c < 2000) begin
            tx_ready = mask[c % 8];
            if (held && (!tx_valid || tx_data !== hd || tx_last !== hl)) stable_err++;
            held = 1'b0;
            if (tx_valid && tx_ready) begin
                if (nbytes < 80) got_b[nbytes] = tx_data;
                if (tx_last) last_pos = nbytes;
                nbytes++;
            end else if (tx_valid) begin
                held = 1'b1; hd = tx_data; hl = tx_last;
            end
            @(negedge clk);
            c++;
        end
        tx_ready = 1'b0;
    endtask

    task automatic check_frame(input string tag);
        int bad_hdr;
        int bad_fcs;
        bad_hdr = 0; bad_fcs = 0;
        for (int i = 0; i < 60; i++) if (got_b[i] !== exp_b[i]) bad_hdr++;
        for (int i = 60; i < 64; i++) if (got_b[i] !== exp_b[i]) bad_fcs++;
        check({"R3 header/pad bytes ", tag}, 64'(bad_hdr), 64'd0);
        check({"R4 fcs bytes ", tag}, 64'(bad_fcs), 64'd0);
        check({"R4 tx_last position ", tag}, 64'(last_pos), 64'd63);
        check({"R5 stable while stalled ", tag}, 64'(stable_err), 64'd0);
        check({"R6 busy clears after last ", tag}, 64'(busy), 64'd0);
    endtask

    initial begin
        logic [15:0] vpt;
        logic [47:0] vmac;
        logic [7:0]  vmask;

        repeat (3) @(negedge clk);
        check("R1 busy after reset", 64'(busy), 64'd0);
        check("R1 back_pressure after reset", 64'(back_pressure), 64'd0);
        check("R1 tx_valid after reset", 64'(tx_valid), 64'd0);
        check("R1 readback after reset", 64'(cfg_rd_data), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: plain write while idle
        do_write(32'h1234_0000);
        check("R2 readback after idle write", 64'(cfg_rd_data), 64'h1234_0000);
        check("R2 no busy without request", 64'(busy), 64'd0);

        // vector table: full-duplex frames
        for (int v = 0; v < NVEC; v++) begin
            {vpt, vmac, vmask} = VEC[v];
            station_addr = vmac;
            full_duplex  = 1'b1;
            tx_enable    = 1'b1;
            build_expected(vpt, vmac);
            do_write({vpt, 16'h0001});
            check("R6 busy rises after request", 64'(busy), 64'd1);
            check("R2 readback busy bit", 64'(cfg_rd_data[1:0]), 64'd1);
            collect(vmask);
            check_frame($sformatf("vec%0d", v));
            @(negedge clk);
        end

        // R10: write during frame ignored
        station_addr = 48'h0102_0304_0506;
        build_expected(16'h0A0B, 48'h0102_0304_0506);
        do_write(32'h0A0B_0001);
        repeat (3) @(negedge clk);
        do_write(32'hFFFF_0001);
        check("R10 pause time kept during frame", 64'(cfg_rd_data[31:16]), 64'h0A0B);
        collect(8'hFF);
        check_frame("busy-write");

        // R7/R8: half duplex back pressure
        full_duplex = 1'b0;
        do_write(32'h4444_0001);
        check("R7 back_pressure rises", 64'(back_pressure), 64'd1);
        check("R7 busy rises", 64'(busy), 64'd1);
        tx_ready = 1'b1;
        repeat (10) @(negedge clk);
        check("R7 no stream in half duplex", 64'(tx_valid), 64'd0);
        check("R7 back_pressure held", 64'(back_pressure), 64'd1);
        do_write(32'h5555_0001);
        check("R10 hold kept on request write", 64'(back_pressure), 64'd1);
        check("R10 pause time kept in hold", 64'(cfg_rd_data[31:16]), 64'h4444);
        do_write(32'h0000_0000);
        check("R8 back_pressure released", 64'(back_pressure), 64'd0);
        check("R8 busy released", 64'(busy), 64'd0);
        tx_ready = 1'b0;

        // R9: transmitter disabled
        tx_enable = 1'b0;
        do_write(32'hBEEF_0001);
        repeat (5) @(negedge clk);
        check("R9 no back pressure when disabled", 64'(back_pressure), 64'd0);
        check("R9 no busy when disabled", 64'(busy), 64'd0);
        check("R9 pause time stored when disabled", 64'(cfg_rd_data[31:16]), 64'hBEEF);
        full_duplex = 1'b1;
        do_write(32'hBEEF_0001);
        repeat (5) @(negedge clk);
        check("R9 no frame when disabled", 64'(tx_valid), 64'd0);
        check("R9 busy stays low when disabled", 64'(busy), 64'd0);
        // enable dropping during hold
        full_duplex = 1'b0;
        tx_enable = 1'b1;
        do_write(32'h0100_0001);
        check("R7 back_pressure before disable", 64'(back_pressure), 64'd1);
        tx_enable = 1'b0;
        @(negedge clk);
        check("R9 disable releases back pressure", 64'(back_pressure), 64'd0);
        check("R9 disable clears busy", 64'(busy), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule